// File: doc/BRIEF.md
# L2 Directory Lookup with Movable Index Field

After a first-level cache miss, this block decides where the missing line must be fetched from. It takes a few bits out of the miss address and uses them as an index into a small directory. The position of those bits is set at run time through a shift register. Each directory entry names the destination tile by its X and Y coordinates. The entry also flags whether that tile is a second-level cache tile or an off-chip memory controller. Finally, it holds a replacement pattern for the same bits it was indexed by.

The forwarded request carries a rewritten address. The index bits are replaced by the entry's pattern, and every other bit passes through. This gives a cheap page-style translation at the same granularity as the index. Placing the field at low bit positions spreads consecutive lines over many destination tiles. Placing it higher keeps contiguous regions on one tile.

Software programs the entries and the shift through a write port. A lookup has a latency of one clock. The request kind and the return address travel beside the translated address without change.

Top module: `dir_lookup`

## Requirements
- R1: In reset, and in the first cycle after it, `fwd_valid` is 0 and the index shift is 0. Every entry i resets to destination (0,0), `fwd_to_mem`=1 and replacement pattern i, so a lookup after reset forwards the address unchanged to a memory controller at (0,0).
- R2: `fwd_valid` is 1 exactly one cycle after a cycle with `miss_valid`=1. At that point `fwd_kind` and `fwd_ret` equal the `miss_kind` and `miss_ret` of that request.
- R3: The entry index is the 4-bit field `miss_addr[shift+3:shift]`. The selected entry's X, Y and memory-controller flag appear on `fwd_tile_x`, `fwd_tile_y` and `fwd_to_mem`.
- R4: `fwd_addr` equals `miss_addr`, except that bits `[shift+3:shift]` are replaced by the selected entry's 4-bit replacement pattern.
- R5: A shift write (`cfg_shift_we`=1) does not affect a lookup in the same cycle. It applies to lookups from the next cycle on.
- R6: A written shift above ADDR_W-4 (28 by default) is stored as ADDR_W-4.
- R7: An entry write and a lookup of the same entry in one cycle return the old entry contents. The new contents apply from the next cycle.
- R8: One cycle after a cycle with `miss_valid`=0, `fwd_valid` is 0 and `fwd_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | A miss request is present |
| miss_addr | input | ADDR_W | Missing address |
| miss_kind | input | 2 | Request kind: 0 load, 1 store, 2 line fetch, 3 flush |
| miss_ret | input | RET_W | Return address of the requester |
| cfg_entry_we | input | 1 | Write one directory entry |
| cfg_entry_idx | input | 4 | Entry to write |
| cfg_to_mem | input | 1 | New entry: destination is a memory controller |
| cfg_tile_x | input | 3 | New entry: destination X |
| cfg_tile_y | input | 3 | New entry: destination Y |
| cfg_repl | input | 4 | New entry: replacement pattern |
| cfg_shift_we | input | 1 | Write the index shift |
| cfg_shift | input | SHIFT_W | New index shift (clamped) |
| fwd_valid | output | 1 | Forwarded request present |
| fwd_addr | output | ADDR_W | Translated address |
| fwd_kind | output | 2 | Request kind, passed through |
| fwd_ret | output | RET_W | Return address, passed through |
| fwd_to_mem | output | 1 | Destination is a memory controller |
| fwd_tile_x | output | 3 | Destination X |
| fwd_tile_y | output | 3 | Destination Y |

## Verification
A corrupted shift register moves the window. The next forwarded address then has changed bits outside the expected nibble, or has the replacement in the wrong place, and this shows one cycle after the lookup. A stale or misrouted entry shows as a wrong destination or pattern in the same cycle. The same-cycle cases check that writes land only at the clock edge. To do that, the old and the new contents are observed on two consecutive forwarded requests.

// File: rtl/dir_lookup_pkg.sv
package dir_lookup_pkg;

    localparam int DL_IDX_W   = 4;
    localparam int DL_ENTRIES = 1 << DL_IDX_W;
    localparam int DL_TX_W    = 3;
    localparam int DL_TY_W    = 3;
    localparam int DL_KIND_W  = 2;

    typedef enum logic [DL_KIND_W-1:0] {
        MK_LOAD       = 2'd0,
        MK_STORE      = 2'd1,
        MK_LINE_FETCH = 2'd2,
        MK_FLUSH      = 2'd3
    } miss_kind_t;

    typedef struct packed {
        logic                to_mem;
        logic [DL_TX_W-1:0]  tile_x;
        logic [DL_TY_W-1:0]  tile_y;
        logic [DL_IDX_W-1:0] repl;
    } dir_entry_t;

    function automatic dir_entry_t dl_reset_entry(input int idx);
        dir_entry_t e;
        e.to_mem = 1'b1;
        e.tile_x = '0;
        e.tile_y = '0;
        e.repl   = DL_IDX_W'(idx);
        return e;
    endfunction

endpackage

// File: rtl/dl_shift_reg.sv
module dl_shift_reg
    import dir_lookup_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SHIFT_W = $clog2(ADDR_W - DL_IDX_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SHIFT_W-1:0] wr_val,
    output logic [SHIFT_W-1:0] shift_q
);
    localparam logic [SHIFT_W-1:0] SHIFT_MAX = SHIFT_W'(ADDR_W - DL_IDX_W);

    logic [SHIFT_W-1:0] clamped;

    always_comb begin
        clamped = (wr_val > SHIFT_MAX) ? SHIFT_MAX : wr_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else if (wr_en) begin
            shift_q <= clamped;
        end
    end
endmodule

// File: rtl/dl_dir_store.sv
module dl_dir_store
    import dir_lookup_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DL_IDX_W-1:0] wr_idx,
    input  dir_entry_t          wr_data,
    input  logic [DL_IDX_W-1:0] rd_idx,
    output dir_entry_t          rd_data
);
    dir_entry_t ent_q [DL_ENTRIES];

    for (genvar g = 0; g < DL_ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= dl_reset_entry(g);
            end else if (wr_en && (wr_idx == DL_IDX_W'(g))) begin
                ent_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = ent_q[rd_idx];
    end
endmodule

// File: rtl/dl_addr_xlate.sv
module dl_addr_xlate
    import dir_lookup_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SHIFT_W = $clog2(ADDR_W - DL_IDX_W + 1)
) (
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic [SHIFT_W-1:0]  shift,
    input  logic [DL_IDX_W-1:0] repl,
    output logic [DL_IDX_W-1:0] idx,
    output logic [ADDR_W-1:0]   addr_out
);
    logic [ADDR_W-1:0] field_mask;
    logic [ADDR_W-1:0] repl_placed;

    always_comb begin
        idx         = DL_IDX_W'(addr_in >> shift);
        field_mask  = ADDR_W'({DL_IDX_W{1'b1}}) << shift;
        repl_placed = ADDR_W'(repl) << shift;
        addr_out    = (addr_in & ~field_mask) | repl_placed;
    end
endmodule

// File: rtl/dir_lookup.sv
module dir_lookup
    import dir_lookup_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int RET_W   = 6,
    parameter int SHIFT_W = $clog2(ADDR_W - DL_IDX_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 miss_valid,
    input  logic [ADDR_W-1:0]    miss_addr,
    input  logic [DL_KIND_W-1:0] miss_kind,
    input  logic [RET_W-1:0]     miss_ret,
    input  logic                 cfg_entry_we,
    input  logic [DL_IDX_W-1:0]  cfg_entry_idx,
    input  logic                 cfg_to_mem,
    input  logic [DL_TX_W-1:0]   cfg_tile_x,
    input  logic [DL_TY_W-1:0]   cfg_tile_y,
    input  logic [DL_IDX_W-1:0]  cfg_repl,
    input  logic                 cfg_shift_we,
    input  logic [SHIFT_W-1:0]   cfg_shift,
    output logic                 fwd_valid,
    output logic [ADDR_W-1:0]    fwd_addr,
    output logic [DL_KIND_W-1:0] fwd_kind,
    output logic [RET_W-1:0]     fwd_ret,
    output logic                 fwd_to_mem,
    output logic [DL_TX_W-1:0]   fwd_tile_x,
    output logic [DL_TY_W-1:0]   fwd_tile_y
);
    logic [SHIFT_W-1:0]  shift_q;
    logic [DL_IDX_W-1:0] look_idx;
    dir_entry_t          look_ent;
    dir_entry_t          wr_ent;
    logic [ADDR_W-1:0]   xl_addr;

    logic                valid_q;
    logic [ADDR_W-1:0]   addr_q;
    miss_kind_t          kind_q;
    logic [RET_W-1:0]    ret_q;
    dir_entry_t          dest_q;

    always_comb begin
        wr_ent.to_mem = cfg_to_mem;
        wr_ent.tile_x = cfg_tile_x;
        wr_ent.tile_y = cfg_tile_y;
        wr_ent.repl   = cfg_repl;
    end

    dl_shift_reg #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_shift_we),
        .wr_val  (cfg_shift),
        .shift_q (shift_q)
    );

    dl_dir_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_entry_we),
        .wr_idx  (cfg_entry_idx),
        .wr_data (wr_ent),
        .rd_idx  (look_idx),
        .rd_data (look_ent)
    );

    dl_addr_xlate #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_xlate (
        .addr_in  (miss_addr),
        .shift    (shift_q),
        .repl     (look_ent.repl),
        .idx      (look_idx),
        .addr_out (xl_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            kind_q  <= MK_LOAD;
            ret_q   <= '0;
            dest_q  <= '0;
        end else begin
            valid_q <= miss_valid;
            if (miss_valid) begin
                addr_q <= xl_addr;
                kind_q <= miss_kind_t'(miss_kind);
                ret_q  <= miss_ret;
                dest_q <= look_ent;
            end
        end
    end

    assign fwd_valid  = valid_q;
    assign fwd_addr   = addr_q;
    assign fwd_kind   = kind_q;
    assign fwd_ret    = ret_q;
    assign fwd_to_mem = dest_q.to_mem;
    assign fwd_tile_x = dest_q.tile_x;
    assign fwd_tile_y = dest_q.tile_y;
endmodule

// File: rtl/dir_lookup_chk.sv
module dir_lookup_chk
    import dir_lookup_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int RET_W   = 6,
    parameter int SHIFT_W = $clog2(ADDR_W - DL_IDX_W + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 miss_valid,
    input logic [ADDR_W-1:0]    miss_addr,
    input logic [DL_KIND_W-1:0] miss_kind,
    input logic [RET_W-1:0]     miss_ret,
    input logic                 fwd_valid,
    input logic [ADDR_W-1:0]    fwd_addr,
    input logic [DL_KIND_W-1:0] fwd_kind,
    input logic [RET_W-1:0]     fwd_ret,
    input logic [SHIFT_W-1:0]   shift_q
);
    localparam logic [SHIFT_W-1:0] SHIFT_LIMIT = SHIFT_W'(ADDR_W - DL_IDX_W);

    logic [ADDR_W-1:0] win;
    always_comb begin
        win = {{(ADDR_W-DL_IDX_W){1'b0}}, {DL_IDX_W{1'b1}}} << shift_q;
    end

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        miss_valid |=> fwd_valid);

    p_meta_carry_r2: assert property (@(posedge clk) disable iff (rst)
        miss_valid |=> (fwd_kind == $past(miss_kind)) && (fwd_ret == $past(miss_ret)));

    p_outside_kept_r4: assert property (@(posedge clk) disable iff (rst)
        miss_valid |=> (((fwd_addr ^ $past(miss_addr)) & ~$past(win)) == '0));

    p_shift_bound_r6: assert property (@(posedge clk) disable iff (rst)
        shift_q <= SHIFT_LIMIT);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !miss_valid |=> !fwd_valid && $stable(fwd_addr));
endmodule

bind dir_lookup dir_lookup_chk #(.ADDR_W(ADDR_W), .RET_W(RET_W), .SHIFT_W(SHIFT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .miss_valid (miss_valid),
    .miss_addr  (miss_addr),
    .miss_kind  (miss_kind),
    .miss_ret   (miss_ret),
    .fwd_valid  (fwd_valid),
    .fwd_addr   (fwd_addr),
    .fwd_kind   (fwd_kind),
    .fwd_ret    (fwd_ret),
    .shift_q    (shift_q)
);

// File: tb/tb_dir_lookup.sv
`timescale 1ns/1ps
module tb_dir_lookup;
    import dir_lookup_pkg::*;

    localparam int ADDR_W  = 32;
    localparam int RET_W   = 6;
    localparam int SHIFT_W = $clog2(ADDR_W - DL_IDX_W + 1);

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 miss_valid;
    logic [ADDR_W-1:0]    miss_addr;
    logic [DL_KIND_W-1:0] miss_kind;
    logic [RET_W-1:0]     miss_ret;
    logic                 cfg_entry_we;
    logic [DL_IDX_W-1:0]  cfg_entry_idx;
    logic                 cfg_to_mem;
    logic [DL_TX_W-1:0]   cfg_tile_x;
    logic [DL_TY_W-1:0]   cfg_tile_y;
    logic [DL_IDX_W-1:0]  cfg_repl;
    logic                 cfg_shift_we;
    logic [SHIFT_W-1:0]   cfg_shift;
    logic                 fwd_valid;
    logic [ADDR_W-1:0]    fwd_addr;
    logic [DL_KIND_W-1:0] fwd_kind;
    logic [RET_W-1:0]     fwd_ret;
    logic                 fwd_to_mem;
    logic [DL_TX_W-1:0]   fwd_tile_x;
    logic [DL_TY_W-1:0]   fwd_tile_y;

    always #2 clk = ~clk;

    dir_lookup #(.ADDR_W(ADDR_W), .RET_W(RET_W)) dut (.*);

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct packed {
        logic [4:0]  shift;
        logic [31:0] addr;
        logic [1:0]  kind;
        logic [5:0]  ret;
        logic [31:0] exp_addr;
        logic [2:0]  exp_x;
        logic [2:0]  exp_y;
        logic        exp_mem;
    } vec_t;

    // Entries programmed as: x=i[2:0], y={i[3],2'b01}, to_mem=i[0], repl=~i
    localparam vec_t VECS [6] = '{
        '{5'd0,  32'h1234_5678, 2'd0, 6'h11, 32'h1234_5677, 3'd0, 3'd5, 1'b0},
        '{5'd4,  32'h1234_5678, 2'd1, 6'h22, 32'h1234_5688, 3'd7, 3'd1, 1'b1},
        '{5'd28, 32'hA000_0001, 2'd2, 6'h33, 32'h5000_0001, 3'd2, 3'd5, 1'b0},
        '{5'd13, 32'h0000_6000, 2'd3, 6'h04, 32'h0001_8000, 3'd3, 3'd1, 1'b1},
        '{5'd31, 32'hF0FF_FFFF, 2'd0, 6'h3F, 32'h00FF_FFFF, 3'd7, 3'd5, 1'b1},
        '{5'd2,  32'hFFFF_FFC3, 2'd1, 6'h2A, 32'hFFFF_FFFF, 3'd0, 3'd1, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_dest(input string req, input logic [31:0] a, input logic [2:0] x,
                            input logic [2:0] y, input logic m);
        chk({req, " valid"}, 64'(fwd_valid), 64'd1);
        chk({req, " addr"}, 64'(fwd_addr), 64'(a));
        chk({req, " tile_x"}, 64'(fwd_tile_x), 64'(x));
        chk({req, " tile_y"}, 64'(fwd_tile_y), 64'(y));
        chk({req, " to_mem"}, 64'(fwd_to_mem), 64'(m));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        miss_valid = 0; miss_addr = '0; miss_kind = '0; miss_ret = '0;
        cfg_entry_we = 0; cfg_entry_idx = '0; cfg_to_mem = 0;
        cfg_tile_x = '0; cfg_tile_y = '0; cfg_repl = '0;
        cfg_shift_we = 0; cfg_shift = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset valid", 64'(fwd_valid), 64'd0);

        // R1: reset entries forward unchanged to memory controller (0,0)
        miss_valid = 1; miss_addr = 32'hDEAD_BEEF; miss_kind = 2'd2; miss_ret = 6'h15;
        @(negedge clk);
        chk_dest("R1 reset entry", 32'hDEAD_BEEF, 3'd0, 3'd0, 1'b1);
        miss_valid = 0;

        for (int i = 0; i < DL_ENTRIES; i++) begin
            cfg_entry_we = 1; cfg_entry_idx = DL_IDX_W'(i);
            cfg_tile_x = DL_TX_W'(i); cfg_tile_y = {i[3], 2'b01};
            cfg_to_mem = i[0]; cfg_repl = ~DL_IDX_W'(i);
            @(negedge clk);
        end
        cfg_entry_we = 0;

        // R3 R4 R6 R2: table walk
        for (int v = 0; v < 6; v++) begin
            cfg_shift_we = 1; cfg_shift = VECS[v].shift;
            @(negedge clk);
            cfg_shift_we = 0;
            miss_valid = 1; miss_addr = VECS[v].addr;
            miss_kind = VECS[v].kind; miss_ret = VECS[v].ret;
            @(negedge clk);
            miss_valid = 0;
            chk_dest($sformatf("R3 R4 R6 vec%0d", v), VECS[v].exp_addr,
                     VECS[v].exp_x, VECS[v].exp_y, VECS[v].exp_mem);
            chk("R2 kind", 64'(fwd_kind), 64'(VECS[v].kind));
            chk("R2 ret", 64'(fwd_ret), 64'(VECS[v].ret));
        end

        // R8: idle cycle leaves address held and valid low
        @(negedge clk);
        chk("R8 idle valid", 64'(fwd_valid), 64'd0);
        chk("R8 idle addr", 64'(fwd_addr), 64'h0000_0000_FFFF_FFFF);

        // R5: shift write and lookup in one cycle (shift currently 2)
        cfg_shift_we = 1; cfg_shift = 5'd8;
        miss_valid = 1; miss_addr = 32'h0000_013C;
        @(negedge clk);
        chk_dest("R5 old shift", 32'h0000_0100, 3'd7, 3'd5, 1'b1);
        cfg_shift_we = 0;
        @(negedge clk);
        chk_dest("R5 new shift", 32'h0000_0E3C, 3'd1, 3'd1, 1'b1);

        // R7: entry write and lookup of same entry in one cycle
        cfg_entry_we = 1; cfg_entry_idx = 4'd1;
        cfg_tile_x = 3'd6; cfg_tile_y = 3'd2; cfg_to_mem = 0; cfg_repl = 4'd3;
        @(negedge clk);
        chk_dest("R7 old entry", 32'h0000_0E3C, 3'd1, 3'd1, 1'b1);
        cfg_entry_we = 0;
        @(negedge clk);
        chk_dest("R7 new entry", 32'h0000_033C, 3'd6, 3'd2, 1'b0);
        miss_valid = 0;
        @(negedge clk);
        chk("R8 hold valid", 64'(fwd_valid), 64'd0);
        chk("R8 hold addr", 64'(fwd_addr), 64'h0000_033C);

        // R1: reset again restores defaults
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 re-reset valid", 64'(fwd_valid), 64'd0);
        miss_valid = 1; miss_addr = 32'h0000_013C;
        @(negedge clk);
        miss_valid = 0;
        chk_dest("R1 re-reset lookup", 32'h0000_013C, 3'd0, 3'd0, 1'b1);

        finish_run();
    end
endmodule